// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block forms the signed product of two 8-bit two's-complement numbers with radix-2 Booth recoding. It takes one clock cycle per multiplier bit. The design is split into a control FSM and a datapath. The datapath holds four stores:

- a multiplicand register;
- an accumulator that carries the high byte of the product;
- a multiplier register that carries the low byte;
- a one-bit flop that keeps the multiplier bit most recently shifted out.

In each step, the FSM adds the multiplicand to the accumulator, subtracts it, or leaves the accumulator alone. It then shifts the whole accumulator/multiplier chain one place right, keeping the sign.

A START level begins a multiplication. The block carries out exactly one product per press. While START stays high after a product, the block holds its result and does nothing more. Only a release followed by a new press starts the next product. The product is always visible on the output and stays in place until the next load or a reset.

Top module: `booth_mult`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the product output to 0 and drives busy_o and done_o low, even if a multiplication is in progress.
- R2: In the idle state, a rising edge that samples start_i high moves the block to a load cycle. The edge that ends the load cycle copies mcand_i into the multiplicand register and mplier_i into the multiplier register, and clears the accumulator and the shifted-out bit.
- R3: Each step examines the pair {multiplier bit 0, shifted-out bit}. For 10 the step subtracts the multiplicand from the accumulator; for 01 it adds the multiplicand; for 00 and 11 it leaves the accumulator unchanged.
- R4: After the add or subtract, each step shifts {accumulator, multiplier, shifted-out bit} right by one place. The sign of the 9-bit intermediate sum fills the accumulator's top bit, the sum's bit 0 enters the multiplier's top bit, and the old multiplier bit 0 becomes the shifted-out bit.
- R5: product_o (accumulator in bits 15:8, multiplier register in bits 7:0) equals the 16-bit two's-complement product of the operands. This holds for every operand pair, including 14×6=84, −14×6=−84, −6×14=−84, −6×−14=84 and −128×−128=16384.
- R6: Counting the edge that first samples start_i high as edge 1, busy_o is high after edges 1 through 9 and done_o rises after edge 10, with the final product valid at that point.
- R7: While done_o is high and start_i stays high, no new multiplication begins. busy_o stays low, done_o stays high, and product_o is unaffected by changes on mcand_i and mplier_i.
- R8: The first edge that samples start_i low while done_o is high returns the block to idle, with done_o low. A later press then performs a new multiplication.
- R9: busy_o and done_o are never high together. Outside the load and step cycles, product_o does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start level; one product per press |
| mcand_i | input | 8 | Signed multiplicand |
| mplier_i | input | 8 | Signed multiplier |
| product_o | output | 16 | Signed product {accumulator, multiplier register} |
| busy_o | output | 1 | High during the load cycle and the eight step cycles |
| done_o | output | 1 | High from completion until start_i is released |

## Verification
The hardest situation to reach from the ports is a subtraction whose true result does not fit in 8 bits. The clearest case is −128×−128, where the final step subtracts −128 from zero and the sign would flip if the sum were only 8 bits wide. The stimulus sweeps every multiplicand value, including −128, against a set of multipliers that includes −128, −127, −1 and 127. This drives both the add overflow and the subtract overflow into the shift. A second hard point is a press that is held past completion. The bench keeps start_i high for several cycles after done_o rises and changes the operands during that time. It then checks that neither the output nor the flags move.

// File: rtl/booth_pkg.sv
package booth_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_STEP,
    ST_DONE,
    ST_HOLD
  } booth_state_t;

  typedef enum logic [1:0] {
    OP_KEEP,
    OP_ADD,
    OP_SUB
  } booth_op_t;

  // Radix-2 recoding of {current bit, previously shifted-out bit}
  function automatic booth_op_t recode_pair(input logic cur_bit, input logic prev_bit);
    case ({cur_bit, prev_bit})
      2'b10:   return OP_SUB;
      2'b01:   return OP_ADD;
      default: return OP_KEEP;
    endcase
  endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] mcand_i,
  input  logic         cur_bit_i,
  input  logic         prev_bit_i,
  output logic [W:0]   sum_o,
  output booth_pkg::booth_op_t op_o
);
  import booth_pkg::*;

  logic [W:0] acc_x;
  logic [W:0] mc_x;

  // sign extension to W+1 bits keeps the sign through the shift
  assign acc_x = {acc_i[W-1], acc_i};
  assign mc_x  = {mcand_i[W-1], mcand_i};
  assign op_o  = recode_pair(cur_bit_i, prev_bit_i);

  always_comb begin
    case (op_o)
      OP_ADD:  sum_o = acc_x + mc_x;
      OP_SUB:  sum_o = acc_x - mc_x;
      default: sum_o = acc_x;
    endcase
  end

endmodule

// File: rtl/booth_datapath.sv
module booth_datapath #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld_i,
  input  logic           step_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o
);
  import booth_pkg::*;

  logic [W-1:0] mreg;
  logic [W-1:0] acc;
  logic [W-1:0] qreg;
  logic         qm1;
  logic [W:0]   sum;
  booth_op_t    op;

  // named event wires for the assertions
  logic keep_evt;
  assign keep_evt = step_i && (qreg[0] == qm1);

  booth_recode #(.W(W)) i_recode (
    .acc_i     (acc),
    .mcand_i   (mreg),
    .cur_bit_i (qreg[0]),
    .prev_bit_i(qm1),
    .sum_o     (sum),
    .op_o      (op)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mreg <= '0;
      acc  <= '0;
      qreg <= '0;
      qm1  <= 1'b0;
    end else if (ld_i) begin
      mreg <= mcand_i;
      acc  <= '0;
      qreg <= mplier_i;
      qm1  <= 1'b0;
    end else if (step_i) begin
      acc  <= sum[W:1];
      qreg <= {sum[0], qreg[W-1:1]};
      qm1  <= qreg[0];
    end
  end

  assign product_o = {acc, qreg};

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> (acc == '0) && (qm1 == 1'b0) && (mreg == $past(mcand_i)) && (qreg == $past(mplier_i)));

  p_shift_chain_r4: assert property (@(posedge clk) disable iff (rst)
    step_i |=> (qreg[W-2:0] == $past(qreg[W-1:1])) && (qm1 == $past(qreg[0])));

  p_sign_keep_r4: assert property (@(posedge clk) disable iff (rst)
    step_i |=> acc[W-1] == $past(sum[W]));

  p_no_arith_r3: assert property (@(posedge clk) disable iff (rst)
    keep_evt |=> acc == $past({acc[W-1], acc[W-1:1]}));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && !step_i) |=> $stable(product_o));

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic ld_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import booth_pkg::*;

  localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  booth_state_t state;
  logic [CNT_W-1:0] cnt;
  logic last_step;

  assign ld_o      = (state == ST_LOAD);
  assign step_o    = (state == ST_STEP);
  assign busy_o    = ld_o || step_o;
  assign done_o    = (state == ST_DONE) || (state == ST_HOLD);
  assign last_step = step_o && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) state <= ST_LOAD;
        ST_LOAD: begin
          cnt   <= '0;
          state <= ST_STEP;
        end
        ST_STEP: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) state <= ST_DONE;
        end
        ST_DONE: state <= start_i ? ST_HOLD : ST_IDLE;
        ST_HOLD: if (!start_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  p_press_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start_i) |=> ld_o);

  p_finish_r6: assert property (@(posedge clk) disable iff (rst)
    last_step |=> done_o);

  p_once_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && start_i) |=> (done_o && !busy_o));

  p_release_r8: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> (!done_o && !busy_o));

endmodule

// File: rtl/booth_mult.sv
module booth_mult #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [W-1:0]   mcand_i,
  input  logic [W-1:0]   mplier_i,
  output logic [2*W-1:0] product_o,
  output logic           busy_o,
  output logic           done_o
);

  logic ld;
  logic step;

  booth_ctrl #(.W(W)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .ld_o   (ld),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  booth_datapath #(.W(W)) i_dp (
    .clk      (clk),
    .rst      (rst),
    .ld_i     (ld),
    .step_i   (step),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .product_o(product_o)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (product_o == '0) && !busy_o && !done_o);

endmodule

// File: tb/test_booth_mult.sv
module test_booth_mult;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  a = '0;
  logic [7:0]  b = '0;
  logic [15:0] prod;
  logic        busy;
  logic        done;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  booth_mult #(.W(8)) i_booth_mult (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .mcand_i  (a),
    .mplier_i (b),
    .product_o(prod),
    .busy_o   (busy),
    .done_o   (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_mul(input logic [7:0] x, input logic [7:0] y);
    int px = int'($signed(x));
    int py = int'($signed(y));
    int r  = px * py;
    return r[15:0];
  endfunction

  // one full press; timing checked when detail is set
  task automatic run_mul(input logic [7:0] x, input logic [7:0] y, input bit detail);
    @(negedge clk);
    a = x;
    b = y;
    start = 1'b1;
    repeat (9) @(negedge clk);
    if (detail) begin
      chk(busy == 1'b1 && done == 1'b0, "R6 busy before edge 10", int'({busy, done}), 2);
    end
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R6 done after edge 10", int'({busy, done}), 1);
    chk(prod == ref_mul(x, y), "R5 product", int'($signed(prod)), int'($signed(ref_mul(x, y))));
    start = 1'b0;
    @(negedge clk);
    if (detail) begin
      chk(done == 1'b0 && busy == 1'b0, "R8 done falls on release", int'({busy, done}), 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [7:0] bset [24] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h05, 8'h06, 8'h0E, 8'h2A,
                              8'h55, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'h82, 8'hAA, 8'hC3,
                              8'hF2, 8'hF9, 8'hFA, 8'hFC, 8'hFD, 8'hFE, 8'hFF, 8'h40};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prod == 16'h0000, "R1 product after reset", int'(prod), 0);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags after reset", int'({busy, done}), 0);
    rst = 1'b0;

    // R5 named vectors, R3/R4 via the values, R6/R8 timing
    run_mul(8'd14, 8'd6, 1'b1);
    run_mul(8'hF2, 8'd6, 1'b1);
    run_mul(8'hFA, 8'd14, 1'b1);
    run_mul(8'hFA, 8'hF2, 1'b1);
    run_mul(8'h80, 8'h80, 1'b1);
    chk(prod == 16'd16384, "R5 -128x-128", int'(prod), 16384);

    // R2 operands taken at load edge; change after load has no effect
    @(negedge clk);
    a = 8'd7; b = 8'hFD; start = 1'b1;
    repeat (2) @(negedge clk);
    a = 8'd100; b = 8'd100;
    repeat (8) @(negedge clk);
    chk(prod == ref_mul(8'd7, 8'hFD), "R2 operands latched at load",
        int'($signed(prod)), -21);

    // R7 held press: no restart, output ignores operand changes
    held = prod;
    for (int k = 0; k < 6; k++) begin
      a = 8'(k * 37 + 3);
      b = 8'(k * 11 + 9);
      @(negedge clk);
      chk(done == 1'b1 && busy == 1'b0, "R7 held flags", int'({busy, done}), 1);
      chk(prod == held, "R7 held product", int'(prod), int'(held));
    end
    start = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R8 released", int'(done), 0);
    repeat (4) @(negedge clk);
    chk(prod == held && busy == 1'b0, "R9 product kept in idle", int'(prod), int'(held));

    // R8 new press after release works
    run_mul(8'h81, 8'h7F, 1'b1);

    // R1 reset during a multiplication
    @(negedge clk);
    a = 8'h33; b = 8'h44; start = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b1; start = 1'b0;
    @(negedge clk);
    chk(prod == 16'h0000 && busy == 1'b0 && done == 1'b0, "R1 reset mid operation",
        int'(prod), 0);
    rst = 1'b0;

    // R5 sweep: every multiplicand against a set of multipliers
    for (int i = 0; i < 256; i++) begin
      for (int j = 0; j < 24; j++) begin
        run_mul(8'(i), bset[j], 1'b0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule